// File: doc/BRIEF.md
# SPI Frame Clock and Chip-Select Timer

This block times one serial frame for an SPI controller. A one-cycle start request captures a 24-bit timing word and the frame settings: clock polarity, clock phase, frame length and a keep-selected flag. It then asserts chip select and waits a lead interval. Next it produces the serial clock by dividing the functional clock, and after the final clock edge it waits a trail interval. Chip select is released at the end of the trail interval, unless keep-selected was given. A gap interval follows, and then the block reports that the frame is done.

The data shifter that sits beside this block does not count edges. It only follows two strobes, one to sample and one to shift, and each strobe lands in the same cycle as the clock edge it belongs to. All settings are held from the start request until the frame ends, so the controller can set up the next frame's inputs while the current frame is still running. A start request can be accepted in the same cycle in which the done pulse appears, so frames can run back to back.

Top module: `spi_frame_timer`

## Requirements
- R1: While reset is held, and in the cycles after it until a start arrives, chip select, both strobes, done and busy are all low. From the second cycle after reset release, SCK equals the polarity input.
- R2: Each SCK half period lasts B/2 functional clocks, where B = P × S. P is taken from attribute bits 17:16 (codes 0..3 give 2, 3, 5, 7). S is taken from bits 3:0: codes 0..3 give 2, 4, 6, 8, and a code c of 4 or more gives 2^c.
- R3: Chip select goes high in the cycle after start is sampled. The first SCK edge comes L cycles later, where L = (2p+1) × 2^(n+1), with p from bits 23:22 and n from bits 15:12.
- R4: Chip select goes low T cycles after the last SCK edge, where T uses the same encoding with p from bits 21:20 and n from bits 11:8.
- R5: After the trail interval, a gap of G cycles runs (p from bits 19:18, n from bits 7:4). Done is then high for exactly one cycle, G cycles after the trail interval ends. Busy is low in that cycle.
- R6: A frame of len_m1+1 bits makes 2×(len_m1+1) SCK edges. SCK starts at the polarity level, and the first edge drives it to the opposite level.
- R7: Leading edges are the 1st, 3rd, 5th and so on. With phase 0, a sample strobe comes on each leading edge and a shift strobe on each trailing edge. Phase 1 swaps them. A strobe is high in the same cycle in which SCK shows its new level.
- R8: When keep-selected is captured high, the trail and gap intervals still run, but chip select stays high through done and into the next frame.
- R9: A start that arrives while a frame is running is ignored. The frame's timing is unchanged, and no extra edges, strobes or done pulses appear.
- R10: A start given in the done cycle is accepted, and the next frame begins in the following cycle.
- R11: The attribute word, phase, length and keep-selected inputs are captured at start. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle frame start request |
| attr_i | input | 24 | Timing word: baud and delay fields |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Phase: selects which edges sample and which shift |
| len_m1_i | input | 4 | Frame length in bits, minus one |
| keep_i | input | 1 | Keep chip select asserted after this frame |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip-select enable, active high |
| sample_o | output | 1 | Sample strobe for the shifter |
| shift_o | output | 1 | Shift strobe for the shifter |
| done_o | output | 1 | Frame-done pulse |
| busy_o | output | 1 | A frame is in progress |

## Verification
Two functions can fall in the same cycle: the done pulse of one frame and the acceptance of the next start. The bench provokes this by driving start during the done cycle, once while chip select is held by keep-selected and once after chip select has been released.

The scoreboard judges each case from the event timeline. It predicts the first frame's done cycle, then the second frame's chip-select edge (or, when chip select is held, the absence of one), then every SCK edge of the second frame at its predicted cycle. Any missing, extra or late event is reported. A start that collides with a frame in progress is checked the same way, as is an attribute change during a frame.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

    localparam int ATTR_W = 24;
    localparam int LEN_W  = 4;
    localparam int EDGE_W = LEN_W + 2;
    localparam int HALF_W = 17;
    localparam int DLY_W  = 19;
    localparam int CNT_W  = DLY_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_GAP
    } tmg_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [DLY_W-1:0]  lead;
        logic [DLY_W-1:0]  trail;
        logic [DLY_W-1:0]  gap;
    } tmg_counts_t;

    typedef struct packed {
        tmg_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [EDGE_W-1:0] edge_n;
        logic [EDGE_W-1:0] edge_tot;
        tmg_counts_t       cfg;
        logic              pha;
        logic              keep;
        logic              sck;
        logic              cs;
        logic              smp;
        logic              shf;
        logic              done;
    } core_regs_t;

    // Odd multiplier 1/3/5/7 times 2^(sc+1)
    function automatic logic [DLY_W-1:0] delay_cycles(input logic [1:0] pre,
                                                      input logic [3:0] sc);
        logic [2:0] mult;
        mult = {pre, 1'b1};
        return DLY_W'(mult) << ({1'b0, sc} + 5'd1);
    endfunction

    // Half of the SCK period: prime prescaler times half the scaler
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] pre,
                                                      input logic [3:0] sc);
        logic [HALF_W-1:0] p;
        logic [HALF_W-1:0] s;
        case (pre)
            2'd0:    p = HALF_W'(2);
            2'd1:    p = HALF_W'(3);
            2'd2:    p = HALF_W'(5);
            default: p = HALF_W'(7);
        endcase
        if (sc < 4'd4) s = HALF_W'(sc) + HALF_W'(1);
        else           s = HALF_W'(1) << (sc - 4'd1);
        return p * s;
    endfunction

endpackage

// File: rtl/spi_tmg_decode.sv
module spi_tmg_decode
    import spi_tmg_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    output tmg_counts_t       counts
);
    localparam int N_DLY = 3;

    logic [DLY_W-1:0] dly [N_DLY];

    // Delay g: prescaler at 23-2g, scaler at 15-4g (lead, trail, gap)
    for (genvar g = 0; g < N_DLY; g++) begin : g_dly
        assign dly[g] = delay_cycles(attr[22-2*g +: 2], attr[12-4*g +: 4]);
    end

    assign counts.half  = half_period(attr[17:16], attr[3:0]);
    assign counts.lead  = dly[0];
    assign counts.trail = dly[1];
    assign counts.gap   = dly[2];

endmodule

// File: rtl/spi_tmg_core.sv
module spi_tmg_core
    import spi_tmg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  tmg_counts_t      counts_in,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [LEN_W-1:0] len_m1,
    input  logic             keep,
    output logic             sck,
    output logic             cs,
    output logic             sample,
    output logic             shift,
    output logic             done,
    output logic             busy
);
    core_regs_t r_d, r_q;
    logic       expire;
    logic       leading;

    always_comb begin
        r_d      = r_q;
        r_d.smp  = 1'b0;
        r_d.shf  = 1'b0;
        r_d.done = 1'b0;
        expire   = (r_q.cnt == '0);
        leading  = ~r_q.edge_n[0];
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sck = cpol;
                if (start) begin
                    r_d.st       = ST_LEAD;
                    r_d.cfg      = counts_in;
                    r_d.pha      = cpha;
                    r_d.keep     = keep;
                    r_d.edge_n   = '0;
                    r_d.edge_tot = (EDGE_W'(len_m1) + EDGE_W'(1)) << 1;
                    r_d.cs       = 1'b1;
                    r_d.cnt      = CNT_W'(counts_in.lead) - CNT_W'(1);
                end
            end
            ST_LEAD, ST_XFER: begin
                if (expire) begin
                    r_d.sck    = ~r_q.sck;
                    r_d.edge_n = r_q.edge_n + EDGE_W'(1);
                    r_d.smp    = leading ^ r_q.pha;
                    r_d.shf    = ~(leading ^ r_q.pha);
                    if (r_q.edge_n + EDGE_W'(1) == r_q.edge_tot) begin
                        r_d.st  = ST_TRAIL;
                        r_d.cnt = CNT_W'(r_q.cfg.trail) - CNT_W'(1);
                    end else begin
                        r_d.st  = ST_XFER;
                        r_d.cnt = CNT_W'(r_q.cfg.half) - CNT_W'(1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_TRAIL: begin
                if (expire) begin
                    r_d.cs  = r_q.keep;
                    r_d.st  = ST_GAP;
                    r_d.cnt = CNT_W'(r_q.cfg.gap) - CNT_W'(1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck    = r_q.sck;
    assign cs     = r_q.cs;
    assign sample = r_q.smp;
    assign shift  = r_q.shf;
    assign done   = r_q.done;
    assign busy   = (r_q.st != ST_IDLE);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.smp, r_q.shf}));

    // R7
    strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.smp || r_q.shf) |-> (r_q.sck != $past(r_q.sck)));

    // R8
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.smp || r_q.shf) |-> r_q.cs);

    // R4
    quiet_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st inside {ST_TRAIL, ST_GAP}) && ($past(r_q.st) inside {ST_TRAIL, ST_GAP}))
        |-> $stable(r_q.sck));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.st == ST_IDLE));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (r_q.st inside {ST_XFER, ST_TRAIL, ST_GAP})) |=> (r_q.st != ST_LEAD));

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
    import spi_tmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic [LEN_W-1:0]  len_m1_i,
    input  logic              keep_i,
    output logic              sck_o,
    output logic              cs_o,
    output logic              sample_o,
    output logic              shift_o,
    output logic              done_o,
    output logic              busy_o
);
    tmg_counts_t counts;

    spi_tmg_decode u_decode (
        .attr   (attr_i),
        .counts (counts)
    );

    spi_tmg_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .counts_in (counts),
        .cpol      (cpol_i),
        .cpha      (cpha_i),
        .len_m1    (len_m1_i),
        .keep      (keep_i),
        .sck       (sck_o),
        .cs        (cs_o),
        .sample    (sample_o),
        .shift     (shift_o),
        .done      (done_o),
        .busy      (busy_o)
    );

endmodule

// File: tb/tb_spi_frame_timer.sv
module tb_spi_frame_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] attr = '0;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic [3:0]  len_m1 = 4'd3;
    logic        keep = 1'b0;
    logic        sck, cs, smp, shf, done, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit cs_held = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        int    kind;   // 0 cs up, 1 sample, 2 shift, 3 cs down, 4 done
        bit    lvl;
        string tag;
    } ev_t;
    ev_t expq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_frame_timer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .attr_i(attr),
        .cpol_i(cpol), .cpha_i(cpha), .len_m1_i(len_m1), .keep_i(keep),
        .sck_o(sck), .cs_o(cs), .sample_o(smp), .shift_o(shf),
        .done_o(done), .busy_o(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic match(input int kind, input bit lvl);
        ev_t e;
        if (expq.size() == 0) begin
            check(1'b0, "R9 unexpected event", kind, -1);
            return;
        end
        e = expq.pop_front();
        check(e.kind == kind, {e.tag, " event kind"}, kind, e.kind);
        check(e.at == cyc, {e.tag, " event cycle"}, cyc, e.at);
        if (kind == 1 || kind == 2)
            check(e.lvl == lvl, {e.tag, " sck level"}, lvl, e.lvl);
    endtask

    // Monitor: compares observed events against the scoreboard queue
    logic cs_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (cs && !cs_prev) match(0, 1'b0);
            if (smp) match(1, sck);
            if (shf) match(2, sck);
            if (!cs && cs_prev) match(3, 1'b0);
            if (done) match(4, 1'b0);
        end
        cs_prev = cs;
    end

    function automatic int half_of(input int bp, input int bs);
        int pre [4] = '{2, 3, 5, 7};
        int sc;
        sc = (bs < 4) ? 2 * (bs + 1) : (1 << bs);
        return pre[bp] * sc / 2;
    endfunction

    function automatic int dly_of(input int p, input int n);
        int mul [4] = '{1, 3, 5, 7};
        return mul[p] * (1 << (n + 1));
    endfunction

    function automatic ev_t mk(input int at, input int kind, input bit lvl, input string tag);
        ev_t e;
        e.at = at; e.kind = kind; e.lvl = lvl; e.tag = tag;
        return e;
    endfunction

    // Driver: called at a negedge; returns at the negedge of the done cycle
    task automatic frame(input int bp, input int bs, input int cp, input int cn,
                         input int ap, input int an, input int dp, input int dn,
                         input bit pol, input bit pha, input int lm1, input bit kp,
                         input bit poke, input bit scramble, input string tag);
        int c0, h, dcs, dasc, ddt, nb, last, done_at;
        logic [23:0] a;
        a = {2'(cp), 2'(ap), 2'(dp), 2'(bp), 4'(cn), 4'(an), 4'(dn), 4'(bs)};
        h = half_of(bp, bs);
        dcs = dly_of(cp, cn);
        dasc = dly_of(ap, an);
        ddt = dly_of(dp, dn);
        nb = lm1 + 1;
        c0 = cyc + 1;
        if (!cs_held) expq.push_back(mk(c0, 0, 1'b0, {tag, " R3 cs assert"}));
        for (int k = 0; k < 2 * nb; k++) begin
            bit lead_e;
            lead_e = (k % 2 == 0);
            expq.push_back(mk(c0 + dcs + k * h, (lead_e != pha) ? 1 : 2,
                              lead_e ? ~pol : pol,
                              (k == 0) ? {tag, " R3 R6 R7 first edge"} : {tag, " R2 R6 R7 edge"}));
        end
        last = c0 + dcs + (2 * nb - 1) * h;
        if (!kp) expq.push_back(mk(last + dasc, 3, 1'b0, {tag, " R4 cs release"}));
        done_at = last + dasc + ddt;
        expq.push_back(mk(done_at, 4, 1'b0, {tag, " R5 done"}));

        attr = a; cpol = pol; cpha = pha; len_m1 = 4'(lm1); keep = kp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            // R11: change captured inputs mid-frame
            attr = ~a; cpha = ~pha; len_m1 = ~4'(lm1); keep = ~kp;
        end
        if (poke) begin
            while (cyc < c0 + 5) @(negedge clk);
            start = 1'b1;   // R9: start while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (cyc < done_at) @(negedge clk);
        check(busy == 1'b0, {tag, " R5 busy low at done"}, busy, 0);
        check(cs == kp, {tag, " R8 cs level at done"}, cs, kp);
        attr = a; cpha = pha; len_m1 = 4'(lm1); keep = kp;
        cs_held = kp;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        check(cs == 1'b0, "R1 cs in reset", cs, 0);
        check(done == 1'b0 && busy == 1'b0, "R1 done/busy in reset", {done, busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sck == cpol, "R1 sck idle", sck, cpol);
        check(cs == 1'b0 && smp == 1'b0 && shf == 1'b0, "R1 outputs idle", {cs, smp, shf}, 0);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sck == 1'b1, "R6 sck follows polarity in idle", sck, 1);
        mon_on = 1'b1;

        // A: H=2, lead 2, trail 6, gap 4, 4 bits, pol0 pha0
        frame(0, 0, 0, 0, 1, 0, 0, 1, 1'b0, 1'b0, 3, 1'b0, 1'b0, 1'b0, "A");
        repeat (3) @(negedge clk);
        check(sck == 1'b0, "R6 sck back at polarity", sck, 0);

        // B: H=6, lead 20, trail 14, gap 24, 5 bits, pol1 pha1, busy start
        frame(1, 1, 2, 1, 3, 0, 1, 2, 1'b1, 1'b1, 4, 1'b0, 1'b1, 1'b0, "B R9");
        repeat (4) @(negedge clk);

        // C: H=56, lead 8, keep, inputs scrambled mid-frame
        frame(3, 4, 0, 2, 0, 0, 0, 0, 1'b0, 1'b0, 7, 1'b1, 1'b0, 1'b1, "C R8 R11");

        // D: back to back while cs is held, H=15, 16 bits, pha1
        frame(2, 2, 1, 0, 2, 1, 1, 0, 1'b0, 1'b1, 15, 1'b0, 1'b0, 1'b0, "D R10");

        // E: back to back after a release
        frame(0, 1, 1, 1, 0, 1, 2, 0, 1'b1, 1'b0, 5, 1'b0, 1'b0, 1'b0, "E R10");

        repeat (10) @(negedge clk);
        check(expq.size() == 0, "R9 no missing events", expq.size(), 0);
        check(sck == 1'b1 && cs == 1'b0, "R6 idle after final frame", {sck, cs}, 2);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-scope: actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule